// File: doc/BRIEF.md
# Fixed-Latency Backing RAM

This block is a synthesizable word-addressed memory that answers each access after a fixed number of cycles. It lets a CPU with a cache and a CPU without one be compared against the same storage under realistic timings. A compile-time parameter picks the mode. In line mode every access moves a whole four-word cache line and completes six cycles after it is accepted. In word mode every access moves one word and completes two cycles after it is accepted.

A requester raises `req_valid` for one cycle with `req_write`, `req_addr` and, for writes, `req_wdata`. The memory takes the request only when it is idle, holds the address and data internally, and raises `rsp_done` for one cycle when the latency expires. Read data appears on `rsp_rdata` in that cycle. Requests are strictly serialized: anything presented while an access is in flight is dropped. The storage resets to a computed pattern, so no external file is needed.

Top module: `timed_backing_ram`

## Requirements
- R1: During and after reset `rsp_done` is 0 and `rsp_rdata` is all zero. Memory word i holds ((i * 0x9E3779B9) ^ 0x5A5A0000) truncated to 32 bits after reset.
- R2: In line mode a request accepted at clock edge k raises `rsp_done` after edge k+5 (the sixth cycle after the request cycle) and at no other time.
- R3: In word mode a request accepted at clock edge k raises `rsp_done` after edge k+1 (the second cycle after the request cycle).
- R4: A line-mode read returns the four words at base = address with the two low bits cleared; word base+j sits in `rsp_rdata` bits [32j+31:32j]. The two low address bits have no effect.
- R5: A line-mode write stores `req_wdata` bits [32j+31:32j] into word base+j for j = 0..3 and changes no other word.
- R6: A word-mode access reads or writes the single word at the full address, using only bits [31:0] of `req_wdata`; bits [127:32] of `rsp_rdata` are zero in word mode.
- R7: `rsp_done` lasts exactly one cycle. `rsp_rdata` changes only in the `rsp_done` cycle of a read and holds its value otherwise, including across writes.
- R8: A request presented while an access is in flight (from the accepting edge up to the edge on which `rsp_done` rises) is ignored: it neither writes memory nor produces a `rsp_done`.
- R9: A request presented in the `rsp_done` cycle is accepted, and a read accepted after a write's `rsp_done` returns the written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W*LANES | Write data: full line, or word in the low lane |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W*LANES | Read data, valid in the `rsp_done` cycle |

## Verification
The bound checker follows accepted requests from the ports alone and checks on every cycle that a completion comes exactly the mode's latency after acceptance and never earlier, that the completion is a single-cycle pulse, that read data stays still outside completion cycles, and that the upper lanes stay zero in word mode. Whether the right words come back, whether a line write lands on the aligned base, whether a dropped request left memory untouched and whether a write is seen by the next read can only be shown by the bench, which drives one stimulus stream into a line-mode and a word-mode instance and compares both against its own behavioural model each cycle, with directed reads checked against the reset pattern.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  // Reset pattern of memory word idx (32-bit wrap-around arithmetic).
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return (idx * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

endpackage

// File: rtl/tbr_lat_timer.sv
// Counts the fixed access latency of one accepted request.
module tbr_lat_timer #(
  parameter int LAT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign expire = busy && (cnt_q == CW'(1));

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    if (busy) begin
      if (expire) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tbr_store.sv
// Storage array: one line-wide or one word-wide access per completion.
module tbr_store #(
  parameter bit LINE_MODE = 1'b1,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LANES     = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W*LANES-1:0]   wdata,
  output logic [DATA_W*LANES-1:0]   rdata
);
  import tbr_pkg::*;

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LINE_W = DATA_W * LANES;
  localparam int NW     = LINE_MODE ? LANES : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] base;

  generate
    if (LINE_MODE) begin : g_line_base
      assign base = addr & ~ADDR_W'(LANES - 1);
    end else begin : g_word_base
      logic unused_hi;
      assign base      = addr;
      assign unused_hi = ^wdata[LINE_W-1:DATA_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(seed_word(i));
    end else if (wr_en) begin
      for (int j = 0; j < NW; j++) mem[base + ADDR_W'(j)] <= wdata[j*DATA_W +: DATA_W];
    end
  end

  genvar gj;
  generate
    for (gj = 0; gj < NW; gj++) begin : g_rd
      assign rdata[gj*DATA_W +: DATA_W] = mem[base + ADDR_W'(gj)];
    end
    if (NW < LANES) begin : g_rd_zero
      assign rdata[LINE_W-1:NW*DATA_W] = '0;
    end
  endgenerate
endmodule

// File: rtl/timed_backing_ram.sv
// Fixed-latency backing RAM, line mode or word mode by parameter.
module timed_backing_ram #(
  parameter bit LINE_MODE = 1'b1,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int LANES     = 4,
  parameter int LINE_LAT  = 6,
  parameter int WORD_LAT  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W*LANES-1:0] req_wdata,
  output logic                    rsp_done,
  output logic [DATA_W*LANES-1:0] rsp_rdata
);
  localparam int LINE_W = DATA_W * LANES;
  localparam int LAT    = LINE_MODE ? LINE_LAT : WORD_LAT;

  logic              busy, expire, accept;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LINE_W-1:0] wdata_q, wdata_d;
  logic [LINE_W-1:0] rd_line;
  logic [LINE_W-1:0] rdata_d;

  assign accept = req_valid && !busy;

  tbr_lat_timer #(.LAT(LAT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .busy   (busy),
    .expire (expire)
  );

  tbr_store #(
    .LINE_MODE (LINE_MODE),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (expire && wr_q),
    .addr  (addr_q),
    .wdata (wdata_q),
    .rdata (rd_line)
  );

  // Next-state: capture on accept, load read data on read completion.
  always_comb begin
    wr_d    = wr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rsp_rdata;
    if (accept) begin
      wr_d    = req_write;
      addr_d  = req_addr;
      wdata_d = req_wdata;
    end
    if (expire && !wr_q) rdata_d = rd_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
      rsp_done  <= 1'b0;
    end else begin
      wr_q      <= wr_d;
      addr_q    <= addr_d;
      wdata_q   <= wdata_d;
      rsp_rdata <= rdata_d;
      rsp_done  <= expire;
    end
  end
endmodule

// File: rtl/tbr_checker.sv
// Port-level protocol checker, bound to timed_backing_ram.
module tbr_checker #(
  parameter bit LINE_MODE = 1'b1,
  parameter int DATA_W    = 32,
  parameter int LANES     = 4,
  parameter int LINE_LAT  = 6,
  parameter int WORD_LAT  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    rsp_done,
  input logic [DATA_W*LANES-1:0] rsp_rdata
);
  localparam int LAT = LINE_MODE ? LINE_LAT : WORD_LAT;
  localparam int CW  = $clog2(LAT + 2);

  logic          inflight;
  logic [CW-1:0] age;
  logic          take;

  assign take = req_valid && (!inflight || rsp_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight <= 1'b0;
      age      <= '0;
    end else if (take) begin
      inflight <= 1'b1;
      age      <= CW'(1);
    end else if (rsp_done) begin
      inflight <= 1'b0;
      age      <= '0;
    end else if (inflight && age < CW'(LAT)) begin
      age <= age + CW'(1);
    end
  end

  // R2 (line mode) and R3 (word mode): completion exactly LAT after acceptance
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (inflight && age == CW'(LAT)));

  // R8: no completion while the accepted access is still counting
  assert_no_early_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight && age < CW'(LAT)) |-> !rsp_done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> $stable(rsp_rdata));

  generate
    if (!LINE_MODE) begin : g_word_chk
      assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_rdata[DATA_W*LANES-1:DATA_W] == '0);
    end
  endgenerate
endmodule

bind timed_backing_ram tbr_checker #(
  .LINE_MODE (LINE_MODE),
  .DATA_W    (DATA_W),
  .LANES     (LANES),
  .LINE_LAT  (LINE_LAT),
  .WORD_LAT  (WORD_LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata)
);

// File: tb/timed_backing_ram_tb.sv
module timed_backing_ram_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [7:0]   req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic         l_done, w_done;
  logic [127:0] l_rdata, w_rdata;

  always #2 clk = ~clk;

  timed_backing_ram #(.LINE_MODE(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(l_done), .rsp_rdata(l_rdata));

  timed_backing_ram #(.LINE_MODE(1'b0)) u_dut_word (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(w_done), .rsp_rdata(w_rdata));

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  function automatic logic [31:0] initw(input int i);
    return (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural reference models, one per mode
  logic [31:0]  ml [256];
  logic [31:0]  mw [256];
  bit           lb, wb, lwr, wwr, l_exp_done, w_exp_done;
  int           la, wa, laddr, waddr;
  logic [127:0] lwd, wwd, l_exp_rd, w_exp_rd;

  initial begin
    for (int i = 0; i < 256; i++) begin
      ml[i] = initw(i);
      mw[i] = initw(i);
    end
    lb = 0; wb = 0; la = 0; wa = 0; l_exp_done = 0; w_exp_done = 0;
    l_exp_rd = '0; w_exp_rd = '0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      l_exp_done = 0;
      if (lb) begin
        la++;
        if (la == 6) begin
          lb = 0;
          l_exp_done = 1;
          for (int j = 0; j < 4; j++) begin
            if (lwr) ml[(laddr & 252) + j] = lwd[j*32 +: 32];
            else     l_exp_rd[j*32 +: 32] = ml[(laddr & 252) + j];
          end
        end
      end else if (req_valid) begin
        lb = 1; la = 1; lwr = req_write; laddr = int'(req_addr); lwd = req_wdata;
      end
      w_exp_done = 0;
      if (wb) begin
        wa++;
        if (wa == 2) begin
          wb = 0;
          w_exp_done = 1;
          if (wwr) mw[waddr] = wwd[31:0];
          else     w_exp_rd = {96'b0, mw[waddr]};
        end
      end else if (req_valid) begin
        wb = 1; wa = 1; wwr = req_write; waddr = int'(req_addr); wwd = req_wdata;
      end
    end
  end

  // Cycle-by-cycle comparison (R2 line latency, R3 word latency, R7 hold)
  always @(negedge clk) begin
    if (rst_n) begin
      chk(l_done === l_exp_done, tag, "line done (R2)", {127'b0, l_done}, {127'b0, l_exp_done});
      chk(l_rdata === l_exp_rd, tag, "line rdata (R7)", l_rdata, l_exp_rd);
      chk(w_done === w_exp_done, tag, "word done (R3)", {127'b0, w_done}, {127'b0, w_exp_done});
      chk(w_rdata === w_exp_rd, tag, "word rdata (R7)", w_rdata, w_exp_rd);
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (lb || wb);
    @(negedge clk);
  endtask

  task automatic issue(input bit w, input int a, input logic [127:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 8'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      checks++; fails++;
      $display("FAIL R2 watchdog expired: actual %0d expected below %0d", cyc, 200000);
      finish_run();
    end
  end

  localparam logic [127:0] LINE_A = 128'hD3D3_0003_D2D2_0002_D1D1_0001_D0D0_0000;
  localparam logic [127:0] LINE_B = 128'h4444_4444_3333_3333_2222_2222_1111_1111;

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(l_done == 1'b0 && w_done == 1'b0, "R1", "done in reset", {126'b0, l_done, w_done}, '0);
    chk(l_rdata == '0 && w_rdata == '0, "R1", "rdata in reset", l_rdata | w_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset pattern at the top of memory
    tag = "R1";
    issue(1'b0, 255, '0);
    chk(l_rdata == {initw(255), initw(254), initw(253), initw(252)}, "R1", "line 252",
        l_rdata, {initw(255), initw(254), initw(253), initw(252)});
    chk(w_rdata == {96'b0, initw(255)}, "R1", "word 255", w_rdata, {96'b0, initw(255)});

    // R4 / R6: unaligned address, low bits ignored in line mode
    tag = "R4";
    issue(1'b0, 5, '0);
    chk(l_rdata == {initw(7), initw(6), initw(5), initw(4)}, "R4", "line from addr 5",
        l_rdata, {initw(7), initw(6), initw(5), initw(4)});
    chk(w_rdata == {96'b0, initw(5)}, "R6", "word 5, upper zero", w_rdata, {96'b0, initw(5)});

    // R5 / R6: writes, then read back neighbours
    tag = "R5";
    issue(1'b1, 9, LINE_A);
    issue(1'b0, 10, '0);
    chk(l_rdata == LINE_A, "R5", "line written at base 8", l_rdata, LINE_A);
    chk(w_rdata == {96'b0, initw(10)}, "R6", "word 10 untouched", w_rdata, {96'b0, initw(10)});
    tag = "R6";
    issue(1'b0, 9, '0);
    chk(w_rdata == {96'b0, LINE_A[31:0]}, "R6", "word 9 written", w_rdata, {96'b0, LINE_A[31:0]});
    issue(1'b0, 12, '0);
    chk(l_rdata[31:0] == initw(12), "R5", "next line untouched", {96'b0, l_rdata[31:0]}, {96'b0, initw(12)});

    // R8: write presented while busy is dropped
    tag = "R8";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd20; req_wdata = '0;
    @(negedge clk);
    req_write = 1'b1; req_addr = 8'd40; req_wdata = LINE_B;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    issue(1'b0, 40, '0);
    chk(l_rdata[31:0] == initw(40), "R8", "line addr 40 not written", {96'b0, l_rdata[31:0]}, {96'b0, initw(40)});
    chk(w_rdata == {96'b0, initw(40)}, "R8", "word addr 40 not written", w_rdata, {96'b0, initw(40)});

    // R9: read issued in the write's done cycle sees the write
    tag = "R9";
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'd60; req_wdata = LINE_B;
    @(negedge clk);
    req_valid = 1'b0;
    while (!l_exp_done) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'd60;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk(l_rdata == LINE_B, "R9", "line read after write", l_rdata, LINE_B);
    chk(w_rdata == {96'b0, LINE_B[31:0]}, "R9", "word read after write", w_rdata, {96'b0, LINE_B[31:0]});

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule